// File: doc/BRIEF.md
# Asynchronous SRAM/NOR Memory Controller

This block runs single read and write cycles on a 16-bit external bus to asynchronous static RAM or NOR-style devices. Four chip-select regions are served. Each region carries its own timing word: separate setup, strobe and hold counts for reads and for writes, a turnaround count, and a flag that marks the attached device as 8 bits wide. A count programmed as zero acts as one.

A host raises `req` with a chip select, direction, byte enables, a halfword address and write data, and holds them until `ack`. Only requests with at least one byte enable set are supported. The controller then produces one device cycle in three phases. In the setup phase the chip select goes low and the address is valid. In the strobe phase the write enable or the output enable is low. In the hold phase the strobe is released while the address stays put. On an 8-bit region, each enabled byte becomes its own device cycle, low byte first, and the chip select stays low between the two. Between accesses of different direction, or to a different region, idle clocks are added according to the turnaround count of the region just used.

The device data bus is given as separate output, input and output-enable signals, so that the pad ring can build the tri-state driver. Each timing word is written and read back through a small configuration port.

Top module: `asmc_top`

## Requirements
- R1: Out of reset, all chip selects, write enable, output enable and both byte enables are high. `ack`, `mem_d_oe`, `rdata` and every timing word are zero.
- R2: Every device cycle begins with a setup phase lasting max(S,1) clocks. In this phase the selected chip select is low and both strobes are high. S is the region's read-setup field for reads and its write-setup field for writes.
- R3: The strobe phase lasts max(T,1) clocks, with T taken from the read- or write-strobe field. Writes drive `mem_we_n` low with `mem_oe_n` high. Reads drive `mem_oe_n` low with `mem_we_n` high. The two are never low together.
- R4: The hold phase lasts max(H,1) clocks, with both strobes high and the chip select still low. `ack` is high for exactly the last clock of the final hold phase of the access.
- R5: A region whose six timing fields are all zero gives setup, strobe and hold phases of exactly one clock each.
- R6: After an access ends, the chip selects stay high for at least one clock. If the next request differs in direction or region, they stay high for max(N,1) clocks, where N is the turnaround field of the previous region. A request that arrives after that many clocks have already passed starts on the clock after it is presented.
- R7: `mem_d_oe` is 1 exactly while a write cycle holds its chip select low, and 0 at all other times. On a 16-bit region `mem_d_o` carries the request's write data.
- R8: Read data is captured on the last strobe clock. It is valid in `rdata` while `ack` is high, and it stays unchanged until the next read captures.
- R9: On a 16-bit region, during the access `mem_be_n` equals the inverse of `req_be` (bit 0 = data lines 7:0, bit 1 = lines 15:8) and `mem_a` = {req_addr, 0}. Address and byte enables are stable within each device cycle.
- R10: On an 8-bit region, each enabled byte is its own device cycle, low byte first. `mem_be_n` = 2'b10 and `mem_a` = {req_addr, lane}, where lane 0 is the low byte. Write bytes go out on `mem_d_o[7:0]`. The read byte comes from `mem_d_i[7:0]` into the lane's half of `rdata`.
- R11: Writing `cfg_wdata` with `cfg_we` stores bits 29:0 into the region selected by `cfg_sel`. `cfg_rdata` returns that word with bits 31:30 zero, in the same clock as `cfg_sel`. The layout from bit 0 upward is: read setup (4 bits), read strobe (6), read hold (3), write setup (4), write strobe (6), write hold (3), turnaround (3), 8-bit flag (1).
- R12: At most one chip select is low at any time, and it is the one named by `req_cs` of the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Access request, held until ack |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_cs | input | 2 | Region number |
| req_be | input | 2 | Byte enables, active high |
| req_addr | input | AW (20) | Halfword address |
| req_wdata | input | 16 | Write data |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Captured read data |
| cfg_we | input | 1 | Timing word write strobe |
| cfg_sel | input | 2 | Region of the timing word |
| cfg_wdata | input | 32 | Timing word to write |
| cfg_rdata | output | 32 | Timing word of the selected region |
| mem_cs_n | output | 4 | Chip selects, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | 2 | Byte enables, active low |
| mem_a | output | AW+1 (21) | Device address |
| mem_d_o | output | 16 | Data driven to the device |
| mem_d_i | input | 16 | Data returned by the device |
| mem_d_oe | output | 1 | Data driver enable |

## Verification
A request seen in an idle clock with no turnaround pending pulls the chip select low on the next clock. After that, the phases run for exactly max(S,1), max(T,1) and max(H,1) clocks, and `ack` and the captured `rdata` show up together in the last hold clock. The bench samples every output on the falling edge and sorts each sampled clock as pre-strobe, strobe or post-strobe from the strobe pins it sees. It then compares the per-phase totals, the chip-select-high gap before each access and the address, byte-enable and data values latched at the strobe clock of each byte lane against counts derived from the timing words. Timing words are written on one rising edge and read back from `cfg_rdata` half a clock later.

// File: rtl/asmc_pkg.sv
package asmc_pkg;

    localparam int SETUP_W  = 4;
    localparam int STROBE_W = 6;
    localparam int HOLD_W   = 3;
    localparam int TURN_W   = 3;
    localparam int CFG_W    = 32;
    localparam int DATA_W   = 16;

    localparam int CNT_W = (STROBE_W >= SETUP_W && STROBE_W >= HOLD_W) ? STROBE_W :
                           ((SETUP_W >= HOLD_W) ? SETUP_W : HOLD_W);

    typedef struct packed {
        logic                width8;
        logic [TURN_W-1:0]   turn;
        logic [HOLD_W-1:0]   whold;
        logic [STROBE_W-1:0] wstrobe;
        logic [SETUP_W-1:0]  wsetup;
        logic [HOLD_W-1:0]   rhold;
        logic [STROBE_W-1:0] rstrobe;
        logic [SETUP_W-1:0]  rsetup;
    } cs_cfg_t;

    localparam int CS_CFG_BITS = $bits(cs_cfg_t);

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } phase_e;

    function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
        return (v == '0) ? CNT_W'(1) : v;
    endfunction

endpackage

// File: rtl/asmc_cfg.sv
module asmc_cfg
    import asmc_pkg::*;
#(
    parameter int NCS = 4,
    localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [CSW-1:0]           cfg_sel,
    input  logic [CFG_W-1:0]         cfg_wdata,
    output logic [CFG_W-1:0]         cfg_rdata,
    output cs_cfg_t [NCS-1:0]        cfg_all
);

    logic unused_cfg_hi;
    assign unused_cfg_hi = ^cfg_wdata[CFG_W-1:CS_CFG_BITS];

    for (genvar g = 0; g < NCS; g++) begin : g_word
        cs_cfg_t word_d, word_q;

        always_comb begin
            word_d = word_q;
            if (cfg_we && cfg_sel == CSW'(g)) begin
                word_d = cs_cfg_t'(cfg_wdata[CS_CFG_BITS-1:0]);
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else begin
                word_q <= word_d;
            end
        end

        assign cfg_all[g] = word_q;
    end

    assign cfg_rdata = CFG_W'(cfg_all[cfg_sel]);

    AST_CFG_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_all[$past(cfg_sel)] == $past(cfg_wdata[CS_CFG_BITS-1:0]))); // R11

endmodule

// File: rtl/asmc_seq.sv
module asmc_seq
    import asmc_pkg::*;
#(
    parameter int NCS = 4,
    parameter int AW  = 20,
    localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic [CSW-1:0]    req_cs,
    input  logic [1:0]        req_be,
    input  logic [AW-1:0]     req_addr,
    input  cs_cfg_t [NCS-1:0] cfg_all,
    output logic              ack,
    output logic              accept,
    output logic              cap_en,
    output logic              lane,
    output logic              w8,
    output logic              wr_active,
    output logic [NCS-1:0]    mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [1:0]        mem_be_n,
    output logic [AW:0]       mem_a
);

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
        logic [CSW-1:0]    cs;
        logic              wr;
        logic [1:0]        be;
        logic [AW-1:0]     addr;
        logic              w8;
        logic              lane;
        logic              hi_pend;
        logic [CNT_W-1:0]  t_setup;
        logic [CNT_W-1:0]  t_strobe;
        logic [CNT_W-1:0]  t_hold;
        logic [TURN_W-1:0] turn;
        logic [CSW-1:0]    last_cs;
        logic              last_wr;
        logic [TURN_W-1:0] tcnt;
    } seq_t;

    seq_t q, n;

    cs_cfg_t          sel_cfg;
    logic [CNT_W-1:0] ld_setup, ld_strobe, ld_hold;
    logic             same_kind;
    logic             active;

    always_comb begin
        sel_cfg   = cfg_all[req_cs];
        ld_setup  = at_least_one(req_wr ? CNT_W'(sel_cfg.wsetup)  : CNT_W'(sel_cfg.rsetup));
        ld_strobe = at_least_one(req_wr ? CNT_W'(sel_cfg.wstrobe) : CNT_W'(sel_cfg.rstrobe));
        ld_hold   = at_least_one(req_wr ? CNT_W'(sel_cfg.whold)   : CNT_W'(sel_cfg.rhold));
        same_kind = (req_cs == q.last_cs) && (req_wr == q.last_wr);

        n      = q;
        ack    = 1'b0;
        accept = 1'b0;
        cap_en = 1'b0;

        unique case (q.phase)
            PH_IDLE: begin
                if (q.tcnt != '0) begin
                    n.tcnt = q.tcnt - 1'b1;
                end
                if (req && (q.tcnt == '0 || same_kind)) begin
                    accept    = 1'b1;
                    n.phase   = PH_SETUP;
                    n.cnt     = ld_setup - 1'b1;
                    n.cs      = req_cs;
                    n.wr      = req_wr;
                    n.be      = req_be;
                    n.addr    = req_addr;
                    n.w8      = sel_cfg.width8;
                    n.lane    = sel_cfg.width8 & ~req_be[0];
                    n.hi_pend = sel_cfg.width8 & req_be[0] & req_be[1];
                    n.t_setup = ld_setup;
                    n.t_strobe = ld_strobe;
                    n.t_hold  = ld_hold;
                    n.turn    = sel_cfg.turn;
                    n.tcnt    = '0;
                end
            end
            PH_SETUP: begin
                if (q.cnt == '0) begin
                    n.phase = PH_STROBE;
                    n.cnt   = q.t_strobe - 1'b1;
                end else begin
                    n.cnt = q.cnt - 1'b1;
                end
            end
            PH_STROBE: begin
                if (q.cnt == '0) begin
                    cap_en  = ~q.wr;
                    n.phase = PH_HOLD;
                    n.cnt   = q.t_hold - 1'b1;
                end else begin
                    n.cnt = q.cnt - 1'b1;
                end
            end
            PH_HOLD: begin
                if (q.cnt == '0) begin
                    if (q.hi_pend) begin
                        n.phase   = PH_SETUP;
                        n.lane    = 1'b1;
                        n.hi_pend = 1'b0;
                        n.cnt     = q.t_setup - 1'b1;
                    end else begin
                        ack       = 1'b1;
                        n.phase   = PH_IDLE;
                        n.last_cs = q.cs;
                        n.last_wr = q.wr;
                        n.tcnt    = (q.turn > TURN_W'(1)) ? q.turn - TURN_W'(1) : '0;
                    end
                end else begin
                    n.cnt = q.cnt - 1'b1;
                end
            end
            default: n = q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    assign active = (q.phase != PH_IDLE);

    for (genvar g = 0; g < NCS; g++) begin : g_cs
        assign mem_cs_n[g] = ~(active && q.cs == CSW'(g));
    end

    assign mem_we_n  = ~(q.phase == PH_STROBE && q.wr);
    assign mem_oe_n  = ~(q.phase == PH_STROBE && !q.wr);
    assign mem_be_n  = !active ? 2'b11 : (q.w8 ? 2'b10 : ~q.be);
    assign mem_a     = {q.addr, q.w8 & q.lane};
    assign wr_active = active & q.wr;
    assign lane      = q.lane;
    assign w8        = q.w8;

    AST_ONE_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~mem_cs_n) <= 1); // R12

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n)); // R3

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R4

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && lane == $past(lane)) |-> ($stable(mem_a) && $stable(mem_be_n))); // R9

    AST_STROBE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n || !mem_oe_n) |-> !(&mem_cs_n)); // R2

endmodule

// File: rtl/asmc_dpath.sv
module asmc_dpath
    import asmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              cap_en,
    input  logic              lane,
    input  logic              w8,
    input  logic              wr_active,
    input  logic [DATA_W-1:0] mem_d_i,
    output logic [DATA_W-1:0] mem_d_o,
    output logic              mem_d_oe,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } dp_t;

    dp_t q, n;

    always_comb begin
        n = q;
        if (accept) begin
            n.wdata = req_wdata;
        end
        if (cap_en) begin
            if (!w8) begin
                n.rdata = mem_d_i;
            end else if (lane) begin
                n.rdata[15:8] = mem_d_i[7:0];
            end else begin
                n.rdata[7:0] = mem_d_i[7:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    assign mem_d_o  = w8 ? {8'h00, (lane ? q.wdata[15:8] : q.wdata[7:0])} : q.wdata;
    assign mem_d_oe = wr_active;
    assign rdata    = q.rdata;

    AST_CAPTURE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |-> !wr_active); // R8

    AST_RDATA_ONLY_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_en && !accept) |=> $stable(rdata)); // R8

endmodule

// File: rtl/asmc_top.sv
module asmc_top
    import asmc_pkg::*;
#(
    parameter int NCS = 4,
    parameter int AW  = 20,
    localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic [CSW-1:0]    req_cs,
    input  logic [1:0]        req_be,
    input  logic [AW-1:0]     req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    input  logic              cfg_we,
    input  logic [CSW-1:0]    cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    output logic [NCS-1:0]    mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [1:0]        mem_be_n,
    output logic [AW:0]       mem_a,
    output logic [DATA_W-1:0] mem_d_o,
    input  logic [DATA_W-1:0] mem_d_i,
    output logic              mem_d_oe
);

    cs_cfg_t [NCS-1:0] cfg_all;
    logic              accept;
    logic              cap_en;
    logic              lane;
    logic              w8;
    logic              wr_active;

    asmc_cfg #(.NCS(NCS)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .cfg_all   (cfg_all)
    );

    asmc_seq #(.NCS(NCS), .AW(AW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_wr    (req_wr),
        .req_cs    (req_cs),
        .req_be    (req_be),
        .req_addr  (req_addr),
        .cfg_all   (cfg_all),
        .ack       (ack),
        .accept    (accept),
        .cap_en    (cap_en),
        .lane      (lane),
        .w8        (w8),
        .wr_active (wr_active),
        .mem_cs_n  (mem_cs_n),
        .mem_we_n  (mem_we_n),
        .mem_oe_n  (mem_oe_n),
        .mem_be_n  (mem_be_n),
        .mem_a     (mem_a)
    );

    asmc_dpath u_dpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_wdata (req_wdata),
        .cap_en    (cap_en),
        .lane      (lane),
        .w8        (w8),
        .wr_active (wr_active),
        .mem_d_i   (mem_d_i),
        .mem_d_o   (mem_d_o),
        .mem_d_oe  (mem_d_oe),
        .rdata     (rdata)
    );

    AST_DRIVE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_d_oe |-> (mem_oe_n && !(&mem_cs_n))); // R7

endmodule

// File: tb/asmc_top_tb.sv
module asmc_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_wr = 1'b0;
    logic [1:0]  req_cs = '0;
    logic [1:0]  req_be = '0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        ack;
    logic [15:0] rdata;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [3:0]  mem_cs_n;
    logic        mem_we_n;
    logic        mem_oe_n;
    logic [1:0]  mem_be_n;
    logic [20:0] mem_a;
    logic [15:0] mem_d_o;
    logic [15:0] mem_d_i;
    logic        mem_d_oe;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    asmc_top u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_cs(req_cs),
        .req_be(req_be), .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack),
        .rdata(rdata), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_a(mem_a), .mem_d_o(mem_d_o),
        .mem_d_i(mem_d_i), .mem_d_oe(mem_d_oe)
    );

    function automatic logic [15:0] mdl(input logic [20:0] a);
        return {a[7:0] ^ 8'h5A, a[7:0] ^ 8'hC3};
    endfunction

    assign mem_d_i = mdl(mem_a);

    // timing word: rs(4) rt(6) rh(3) ws(4) wt(6) wh(3) turn(3) w8(1), from bit 0
    function automatic logic [29:0] mkcfg(input int rs, input int rt, input int rh,
                                          input int ws, input int wt, input int wh,
                                          input int tn, input int w8);
        return {w8[0], tn[2:0], wh[2:0], wt[5:0], ws[3:0], rh[2:0], rt[5:0], rs[3:0]};
    endfunction

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    logic [29:0] shadow [4];

    function automatic int f_s(input int cs, input logic wr);
        return eff(wr ? int'(shadow[cs][16:13]) : int'(shadow[cs][3:0]));
    endfunction
    function automatic int f_t(input int cs, input logic wr);
        return eff(wr ? int'(shadow[cs][22:17]) : int'(shadow[cs][9:4]));
    endfunction
    function automatic int f_h(input int cs, input logic wr);
        return eff(wr ? int'(shadow[cs][25:23]) : int'(shadow[cs][12:10]));
    endfunction
    function automatic int f_turn(input int cs);
        return int'(shadow[cs][28:26]);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input int cs, input logic [31:0] w);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_sel = cs[1:0];
        cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
        shadow[cs] = w[29:0];
    endtask

    typedef struct packed {
        logic [1:0]  cs;
        logic        wr;
        logic [1:0]  be;
        logic [19:0] addr;
        logic [15:0] wd;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 1'b1, 2'b11, 20'h00010, 16'h1234},
        '{2'd0, 1'b1, 2'b01, 20'h00011, 16'hABCD},
        '{2'd0, 1'b0, 2'b11, 20'h00012, 16'h0000},
        '{2'd1, 1'b0, 2'b11, 20'h00100, 16'h0000},
        '{2'd1, 1'b1, 2'b10, 20'h00101, 16'h5AA5},
        '{2'd2, 1'b1, 2'b11, 20'h00200, 16'hBEEF},
        '{2'd2, 1'b0, 2'b11, 20'h00201, 16'h0000},
        '{2'd2, 1'b0, 2'b10, 20'h00202, 16'h0000},
        '{2'd3, 1'b1, 2'b11, 20'h00300, 16'h0F0F},
        '{2'd3, 1'b0, 2'b01, 20'h00301, 16'h0000},
        '{2'd0, 1'b0, 2'b11, 20'h00002, 16'h0000}
    };

    // Runs one access; called at a falling edge. exp_gap < 0 skips the gap check.
    task automatic do_access(input int cs, input logic wr, input logic [1:0] be,
                             input logic [19:0] addr, input logic [15:0] wd,
                             input int exp_gap);
        int gap = 0, steps = 0, half = 0, pre = 0, str = 0, post = 0;
        int bad_strobe = 0, bad_doe = 0, bad_cs = 0, bad_be = 0;
        logic seen = 1'b0, got_ack = 1'b0, w8;
        logic [20:0] prev_a;
        logic [20:0] obs_a [2];
        logic [15:0] obs_d [2];
        logic [1:0]  exp_be;
        logic [15:0] rd_got, rd_exp, mask;
        int nh, S, T, H;
        string tg;

        w8 = shadow[cs][29];
        nh = (w8 && be == 2'b11) ? 2 : 1;
        S = f_s(cs, wr);
        T = f_t(cs, wr);
        H = f_h(cs, wr);
        exp_be = w8 ? 2'b10 : ~be;
        obs_a[0] = '0; obs_a[1] = '0; obs_d[0] = '0; obs_d[1] = '0;
        rd_got = '0;

        req_cs = cs[1:0]; req_wr = wr; req_be = be; req_addr = addr; req_wdata = wd;
        req = 1'b1;

        forever begin
            @(negedge clk);
            if (!(&mem_cs_n)) break;
            gap++;
            if (gap > 300) break;
        end
        prev_a = mem_a;
        while (!got_ack && steps < 400) begin
            logic stb, oth;
            if (mem_a != prev_a) begin
                half++;
                seen = 1'b0;
            end
            prev_a = mem_a;
            if (mem_cs_n != ~(4'b0001 << cs)) bad_cs++;
            if (mem_be_n != exp_be) bad_be++;
            stb = wr ? !mem_we_n : !mem_oe_n;
            oth = wr ? !mem_oe_n : !mem_we_n;
            if (oth) bad_strobe++;
            if (mem_d_oe != wr) bad_doe++;
            if (stb) begin
                str++;
                seen = 1'b1;
                if (half < 2) begin
                    obs_a[half] = mem_a;
                    obs_d[half] = mem_d_o;
                end
            end else if (!seen) begin
                pre++;
            end else begin
                post++;
            end
            if (ack) begin
                got_ack = 1'b1;
                rd_got = rdata;
            end else begin
                @(negedge clk);
                steps++;
            end
        end
        req = 1'b0;

        chk("R4 ack seen", 32'(got_ack), 32'd1);
        tg = (cs == 1) ? "R5 setup clocks" : "R2 setup clocks";
        chk(tg, pre, nh * S);
        tg = (cs == 1) ? "R5 strobe clocks" : "R3 strobe clocks";
        chk(tg, str, nh * T);
        tg = (cs == 1) ? "R5 hold clocks" : "R4 hold clocks";
        chk(tg, post, nh * H);
        chk("R3 wrong strobe", bad_strobe, 0);
        chk("R7 data enable", bad_doe, 0);
        chk("R12 chip select", bad_cs, 0);
        chk(w8 ? "R10 byte enables" : "R9 byte enables", bad_be, 0);
        if (exp_gap >= 0) chk("R6 idle gap", gap, exp_gap);
        if (w8) chk("R10 device cycles", half + 1, nh);

        for (int h = 0; h < nh; h++) begin
            logic ln;
            ln = w8 ? ((nh == 2) ? h[0] : (be == 2'b10)) : 1'b0;
            chk(w8 ? "R10 address" : "R9 address", 32'(obs_a[h]), 32'({addr, ln}));
            if (wr) begin
                if (w8) chk("R10 write byte", 32'(obs_d[h][7:0]), 32'(ln ? wd[15:8] : wd[7:0]));
                else    chk("R7 write data", 32'(obs_d[h]), 32'(wd));
            end
        end
        if (!wr) begin
            mask = {{8{be[1]}}, {8{be[0]}}};
            if (w8) rd_exp = {mdl({addr, 1'b1})[7:0], mdl({addr, 1'b0})[7:0]};
            else    rd_exp = mdl({addr, 1'b0});
            chk(w8 ? "R10 read data" : "R8 read data", 32'(rd_got & mask), 32'(rd_exp & mask));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] held;
        for (int i = 0; i < 4; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 cs_n", 32'(mem_cs_n), 32'hF);
        chk("R1 we_n/oe_n", 32'({mem_we_n, mem_oe_n}), 32'h3);
        chk("R1 be_n", 32'(mem_be_n), 32'h3);
        chk("R1 ack/d_oe", 32'({ack, mem_d_oe}), 32'h0);
        chk("R1 rdata", 32'(rdata), 32'h0);
        chk("R1 cfg word", cfg_rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        cfg_write(0, {2'b11, mkcfg(2, 3, 1, 1, 4, 2, 3, 0)});
        cfg_write(1, {2'b00, mkcfg(0, 0, 0, 0, 0, 0, 0, 0)});
        cfg_write(2, {2'b00, mkcfg(1, 2, 1, 2, 1, 1, 2, 1)});
        cfg_write(3, {2'b10, mkcfg(3, 5, 2, 0, 2, 3, 5, 0)});
        for (int i = 0; i < 4; i++) begin
            cfg_sel = i[1:0];
            #1;
            chk("R11 readback", cfg_rdata, 32'(shadow[i]));
        end

        for (int i = 0; i < NV; i++) begin
            int eg;
            if (i == 0) begin
                eg = 0;
            end else if (VEC[i].cs != VEC[i-1].cs || VEC[i].wr != VEC[i-1].wr) begin
                eg = (f_turn(int'(VEC[i-1].cs)) > 1) ? f_turn(int'(VEC[i-1].cs)) : 1;
            end else begin
                eg = 1;
            end
            do_access(int'(VEC[i].cs), VEC[i].wr, VEC[i].be, VEC[i].addr, VEC[i].wd, eg);
        end

        @(negedge clk);
        chk("R4 ack one clock", 32'(ack), 32'h0);

        // R6: turnaround already elapsed while idle
        repeat (8) @(negedge clk);
        do_access(3, 1'b1, 2'b11, 20'h00400, 16'hC001, 0);
        // R6: direction change on region 3 right after -> turnaround 5
        do_access(3, 1'b0, 2'b11, 20'h00401, 16'h0000, 5);
        held = rdata;
        // R8: a write leaves rdata untouched
        do_access(3, 1'b1, 2'b11, 20'h00402, 16'h7777, 5);
        @(negedge clk);
        chk("R8 rdata held", 32'(rdata), 32'(held));
        chk("R7 bus released", 32'(mem_d_oe), 32'h0);
        // R10: high byte only on the 8-bit region
        do_access(2, 1'b1, 2'b10, 20'h00500, 16'h9A00, -1);
        // R5: zero-programmed region after long idle
        repeat (4) @(negedge clk);
        do_access(1, 1'b0, 2'b01, 20'h00600, 16'h0000, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule